// File: doc/BRIEF.md
# Decoder Error Statistics Unit

This block sits after a Reed-Solomon decoder. It watches two streams in lockstep: each symbol as it was received and the same symbol after correction. Packet boundaries are marked with a valid strobe, a start marker and an end marker. For every symbol it reports the correction pattern that was applied. Across a codeword it totals how many symbols were corrected and how many bits were flipped. Those totals are shown combinationally on the beat that carries the end marker, so the last symbol's contribution is already included.

A build-time parameter chooses how bits are counted. The full variant gives one total of flipped bits. The split variant gives two totals: bits that arrived as 1 and were corrected to 0, and bits that arrived as 0 and were corrected to 1. The decoder's uncorrectable indication is passed through, but only on the end beat. A beat is consumed only when valid and downstream ready are both high.

Top module: `rs_err_stats`

## Requirements
- R1: While `in_valid` is high, `err_val` equals `in_rx ^ in_fix`. It is zero for a symbol that needed no correction.
- R2: `stat_valid` is high exactly when `in_valid` and `in_eop` are both high. `stat_uncorr` equals `in_uncorr` on that beat and is 0 on every other beat.
- R3: On the end beat, `sym_errs` equals the number of consumed beats of the codeword whose error value is nonzero. This count runs from the start beat to the end beat, both included.
- R4: With SPLIT=0, `bit_errs` on the end beat equals the total number of set bits in the codeword's error values. In this variant `bits_1to0` and `bits_0to1` stay 0.
- R5: With SPLIT=1, `bits_1to0` counts error bits where the received bit is 1, and `bits_0to1` counts error bits where the received bit is 0. In this variant `bit_errs` stays 0.
- R6: Totals saturate instead of wrapping: `sym_errs` stops at 15 and each bit total stops at 127.
- R7: A beat carrying `in_sop` discards the earlier totals and starts the new ones from that beat's own contribution. This holds even when the previous codeword never saw an end beat.
- R8: A beat with `in_valid` low or `out_ready` low leaves the running totals unchanged.
- R9: After reset the running totals are zero. An end beat with no start beat before it reports only its own contribution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Symbol pair present |
| in_sop | input | 1 | First symbol of a codeword |
| in_eop | input | 1 | Last symbol of a codeword |
| in_rx | input | SYM_W | Symbol as received |
| in_fix | input | SYM_W | Symbol after correction |
| in_uncorr | input | 1 | Decoder could not correct the codeword |
| out_ready | input | 1 | Downstream accepts the beat |
| err_val | output | SYM_W | Correction pattern of the current symbol |
| stat_valid | output | 1 | Totals are valid on this beat |
| stat_uncorr | output | 1 | Uncorrectable flag, qualified by the end beat |
| sym_errs | output | SCNT_W | Corrected symbols in the codeword |
| bit_errs | output | BCNT_W | Flipped bits in the codeword (full variant) |
| bits_1to0 | output | BCNT_W | Bits received as 1 and corrected to 0 (split variant) |
| bits_0to1 | output | BCNT_W | Bits received as 0 and corrected to 1 (split variant) |

## Verification
A corrupted running total does not appear at the ports until the next end beat. That beat may be a whole codeword later, so every end beat of every codeword is compared against a reference that rebuilds the totals from the stimulus alone. The error value and the qualified flags are combinational, so a fault there shows within the same beat. Stall beats, idle beats with differing data, restarts without an end beat, and long all-error codewords are mixed in. This exposes lost holds, missing restarts and counters that wrap instead of saturating. Both bit-count variants are instantiated side by side.

// File: rtl/rs_err_stats.sv
module rs_err_stats #(
  parameter int SYM_W  = 8,
  parameter int SCNT_W = 4,
  parameter int BCNT_W = 7,
  parameter bit SPLIT  = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [SYM_W-1:0]  in_rx,
  input  logic [SYM_W-1:0]  in_fix,
  input  logic              in_uncorr,
  input  logic              out_ready,
  output logic [SYM_W-1:0]  err_val,
  output logic              stat_valid,
  output logic              stat_uncorr,
  output logic [SCNT_W-1:0] sym_errs,
  output logic [BCNT_W-1:0] bit_errs,
  output logic [BCNT_W-1:0] bits_1to0,
  output logic [BCNT_W-1:0] bits_0to1
);

  localparam int PW = $clog2(SYM_W + 1);
  localparam logic [SCNT_W:0] SMAX = {1'b0, {SCNT_W{1'b1}}};
  localparam logic [BCNT_W:0] BMAX = {1'b0, {BCNT_W{1'b1}}};

  function automatic logic [PW-1:0] ones(input logic [SYM_W-1:0] x);
    logic [PW-1:0] c;
    c = '0;
    for (int i = 0; i < SYM_W; i++) c = c + PW'(x[i]);
    return c;
  endfunction

  logic beat;
  logic [SYM_W-1:0]  err;
  logic [SCNT_W-1:0] acc_s, nx_s;
  logic [BCNT_W-1:0] acc_a, acc_b, nx_a, nx_b;
  logic [PW-1:0]     inc_a, inc_b;
  logic [SCNT_W:0]   sum_s;
  logic [BCNT_W:0]   sum_a, sum_b;

  assign beat = in_valid & out_ready;
  assign err  = in_rx ^ in_fix;

  generate
    if (SPLIT) begin : g_split
      assign inc_a = ones(in_rx & err);
      assign inc_b = ones(~in_rx & err);
      assign bit_errs  = '0;
      assign bits_1to0 = nx_a;
      assign bits_0to1 = nx_b;
    end else begin : g_full
      assign inc_a = ones(err);
      assign inc_b = '0;
      assign bit_errs  = nx_a;
      assign bits_1to0 = '0;
      assign bits_0to1 = '0;
    end
  endgenerate

  assign sum_s = {1'b0, (in_sop ? '0 : acc_s)} + (SCNT_W+1)'(err != '0);
  assign sum_a = {1'b0, (in_sop ? '0 : acc_a)} + (BCNT_W+1)'(inc_a);
  assign sum_b = {1'b0, (in_sop ? '0 : acc_b)} + (BCNT_W+1)'(inc_b);

  assign nx_s = (sum_s > SMAX) ? SMAX[SCNT_W-1:0] : sum_s[SCNT_W-1:0];
  assign nx_a = (sum_a > BMAX) ? BMAX[BCNT_W-1:0] : sum_a[BCNT_W-1:0];
  assign nx_b = (sum_b > BMAX) ? BMAX[BCNT_W-1:0] : sum_b[BCNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_s <= '0;
      acc_a <= '0;
      acc_b <= '0;
    end else if (beat) begin
      acc_s <= nx_s;
      acc_a <= nx_a;
      acc_b <= nx_b;
    end
  end

  assign err_val     = err;
  assign stat_valid  = in_valid & in_eop;
  assign stat_uncorr = in_valid & in_eop & in_uncorr;
  assign sym_errs    = nx_s;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(acc_s) && $stable(acc_a) && $stable(acc_b)); // R8
  AST_CLEAN_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !in_sop && (in_rx == in_fix) |=> acc_s == $past(acc_s)); // R3
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    beat && !in_sop |=> acc_s >= $past(acc_s) && acc_a >= $past(acc_a) && acc_b >= $past(acc_b)); // R6
  AST_SOP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    beat && in_sop |=> acc_s <= SCNT_W'(1)); // R7
  AST_SYM_LE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (BCNT_W+1)'(acc_s) <= ({1'b0, acc_a} + {1'b0, acc_b})); // R4

endmodule

// File: tb/rs_err_stats_tb.sv
module rs_err_stats_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sop = 0, in_eop = 0, in_uncorr = 0, out_ready = 0;
  logic [7:0] in_rx = 0, in_fix = 0;

  logic [7:0] ev_f, ev_s;
  logic sv_f, sv_s, su_f, su_s;
  logic [3:0] se_f, se_s;
  logic [6:0] be_f, b10_f, b01_f, be_s, b10_s, b01_s;

  int errors = 0, checks = 0;
  int m_sym = 0, m_all = 0, m_10 = 0, m_01 = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_err_stats #(.SPLIT(1'b0)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_rx(in_rx), .in_fix(in_fix), .in_uncorr(in_uncorr), .out_ready(out_ready),
    .err_val(ev_f), .stat_valid(sv_f), .stat_uncorr(su_f), .sym_errs(se_f),
    .bit_errs(be_f), .bits_1to0(b10_f), .bits_0to1(b01_f));

  rs_err_stats #(.SPLIT(1'b1)) u_dut_split (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
    .in_rx(in_rx), .in_fix(in_fix), .in_uncorr(in_uncorr), .out_ready(out_ready),
    .err_val(ev_s), .stat_valid(sv_s), .stat_uncorr(su_s), .sym_errs(se_s),
    .bit_errs(be_s), .bits_1to0(b10_s), .bits_0to1(b01_s));

  function automatic int pc(logic [7:0] x);
    int c = 0;
    for (int i = 0; i < 8; i++) c += int'(x[i]);
    return c;
  endfunction

  function automatic int sat(int v, int mx);
    return (v > mx) ? mx : v;
  endfunction

  task automatic chk(string req, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] act=%0d exp=%0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic step(bit v, bit s, bit e, logic [7:0] rx, logic [7:0] fx, bit u, bit rdy, string tag);
    int bs, ba, b1, b0, ns, na, n1, n0;
    logic [7:0] x;
    in_valid = v; in_sop = s; in_eop = e; in_rx = rx; in_fix = fx; in_uncorr = u; out_ready = rdy;
    #1;
    x  = rx ^ fx;
    bs = s ? 0 : m_sym; ba = s ? 0 : m_all; b1 = s ? 0 : m_10; b0 = s ? 0 : m_01;
    ns = sat(bs + int'(x != 0), 15);
    na = sat(ba + pc(x), 127);
    n1 = sat(b1 + pc(rx & x), 127);
    n0 = sat(b0 + pc(~rx & x), 127);
    if (v) begin
      chk("R1", tag, int'(ev_f), int'(x));
      chk("R1", tag, int'(ev_s), int'(x));
    end
    chk("R2", tag, int'(sv_f), int'(v && e));
    chk("R2", tag, int'(sv_s), int'(v && e));
    chk("R2", tag, int'(su_f), int'(v && e && u));
    chk("R2", tag, int'(su_s), int'(v && e && u));
    if (v && e) begin
      chk("R3", tag, int'(se_f), ns);
      chk("R3", tag, int'(se_s), ns);
      chk("R4", tag, int'(be_f), na);
      chk("R4", tag, int'(b10_f) + int'(b01_f), 0);
      chk("R5", tag, int'(b10_s), n1);
      chk("R5", tag, int'(b01_s), n0);
      chk("R5", tag, int'(be_s), 0);
    end
    @(posedge clk);
    if (v && rdy) begin m_sym = ns; m_all = na; m_10 = n1; m_01 = n0; end
    @(negedge clk);
  endtask

  task automatic packet(int len, int err_every, bit u, string tag);
    for (int i = 0; i < len; i++) begin
      logic [7:0] r, f;
      r = 8'($urandom);
      f = (err_every != 0 && (i % err_every) == 0) ? (r ^ (8'($urandom) | 8'h01)) : r;
      step(1, i == 0, i == len - 1, r, f, u, 1, tag);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(7));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R2", "R9 reset", int'(sv_f) + int'(su_f), 0);
    // R9: end beat without a start after reset reports only itself
    step(1, 0, 1, 8'h3C, 8'h3D, 0, 1, "R9");
    // clean codeword
    packet(6, 0, 0, "R3 clean");
    // errors on alternate symbols, uncorrectable flagged
    packet(10, 2, 1, "R1 errs");
    // R8: idle and stalled beats with differing data
    step(1, 1, 0, 8'h0F, 8'h0E, 0, 1, "R8");
    step(0, 0, 0, 8'hFF, 8'h00, 0, 1, "R8");
    step(1, 0, 0, 8'hAA, 8'h55, 0, 0, "R8");
    step(0, 0, 1, 8'h12, 8'h21, 1, 0, "R8");
    step(1, 0, 0, 8'h80, 8'h00, 0, 1, "R8");
    step(1, 0, 1, 8'h01, 8'h03, 0, 1, "R8");
    // R6: saturation of symbol and bit totals
    for (int i = 0; i < 20; i++) step(1, i == 0, i == 19, 8'($urandom), 8'($urandom) ^ 8'hFF ^ 8'hFF, 0, 1, "R6 mix");
    for (int i = 0; i < 20; i++) step(1, i == 0, i == 19, 8'hFF, 8'h00, 0, 1, "R6 1to0");
    for (int i = 0; i < 20; i++) step(1, i == 0, i == 19, 8'h00, 8'hFF, 0, 1, "R6 0to1");
    // R7: restart without a preceding end beat
    step(1, 1, 0, 8'hF0, 8'h0F, 0, 1, "R7");
    step(1, 0, 0, 8'hF0, 8'h0F, 0, 1, "R7");
    step(1, 1, 0, 8'h01, 8'h00, 0, 1, "R7");
    step(1, 0, 1, 8'h00, 8'h00, 0, 1, "R7");
    // sop and eop on the same beat
    step(1, 1, 1, 8'h5A, 8'hA5, 1, 1, "R7 single");
    // random codewords with stalls
    for (int p = 0; p < 8; p++) begin
      int len = 1 + int'($urandom % 30);
      for (int i = 0; i < len; i++) begin
        logic [7:0] r;
        bit rdy;
        r = 8'($urandom);
        rdy = ($urandom % 4) != 0;
        step(1, i == 0, i == len - 1, r, ($urandom % 3 == 0) ? r ^ 8'($urandom) : r,
             p[0], rdy || i == len - 1, "R3 random");
      end
    end
    step(0, 0, 0, 8'h00, 8'h00, 0, 1, "R2 idle");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule